// File: doc/BRIEF.md
# Bridge Fault and Power-Mode Supervisor

This block decides, clock by clock, whether one motor-bridge controller may drive its switches. Five digital conditions arrive at its inputs: an overcurrent-limit flag, an overtemperature flag, a supply-undervoltage flag, an active-low reset request and an active-low sleep request. The analog sensing lives elsewhere, and only its results are seen here. The block produces a bridge enable, a one-cycle pulse that reinitialises the downstream control logic, a flag telling the input stage to disregard its pins, a flag that stops the charge pump, regulator and clocks, and an active-low fault indication.

Each fault class recovers in its own way. A sustained overcurrent is qualified over a programmable window and then locked until a reset request or an undervoltage cycle. An overtemperature condition removes drive and clears on its own. An undervoltage condition forces the whole block back to its power-down state. Leaving sleep starts a timed wake-up interval before drive is allowed. Both request inputs must be held high for operation.

The block is a single state machine with seven states: POWER_DOWN (undervoltage present), HELD_RESET (reset request low), SLEEP, WAKE (wake-up interval counting), RUN (bridge enabled), HOT (thermal fault), and OC_LOCK (latched overcurrent). Transitions: any state to POWER_DOWN on undervoltage; any state to HELD_RESET on reset low; every state except OC_LOCK to SLEEP on sleep low; POWER_DOWN and HELD_RESET to RUN (or HOT) once released; SLEEP to WAKE on release; WAKE to RUN (or HOT) when the interval expires; RUN to OC_LOCK on a qualified overcurrent; RUN to HOT and HOT back to RUN following the thermal flag. Conditions are checked in this priority order: undervoltage, reset, lock, sleep, then the per-state rules.

Top module: `bridge_supervisor`

## Requirements
- R1: While the undervoltage flag is high, the bridge enable is low, the input-ignore flag is high, the fault output is high and the clock-stop flag is low. When the flag drops with both requests high, the bridge enables on the next edge.
- R2: While the reset request is low, the bridge enable is low, the input-ignore flag is high and the overcurrent flag is not counted. Releasing the reset with both other conditions clear enables the bridge on the next edge.
- R3: An overcurrent flag sampled high on OC_QUAL_CYCLES consecutive edges in RUN moves the block to OC_LOCK on the last of those edges. A run that is shorter, or is broken by a single low sample, has no effect and restarts the count.
- R4: In OC_LOCK the bridge enable and fault output stay low regardless of the overcurrent, thermal and sleep inputs. Only a low reset request or a high undervoltage flag leaves the state.
- R5: A high thermal flag in RUN removes the bridge enable and drives the fault output low on the next edge. The first edge that samples the flag low restores both.
- R6: While the sleep request is low (and no undervoltage, reset or lock applies), the bridge enable is low and both the clock-stop and input-ignore flags are high.
- R7: After sleep is released, the bridge enables on the (WAKE_CYCLES+1)-th edge that samples the release. If sleep is asserted again during the interval, the count starts over from the next release.
- R8: The fault output is low only in OC_LOCK and HOT. An undervoltage condition by itself never drives it low.
- R9: All outputs follow the state register and change on the edge that samples the input. Undervoltage takes priority over reset, reset takes priority over the lock, the lock takes priority over sleep, and sleep takes priority over the thermal fault.
- R10: The logic-reset output is high for exactly one cycle after any edge that moves the block from a non-reset state into POWER_DOWN or HELD_RESET. It does not pulse when moving between those two states.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| ocp_flag_i | input | 1 | Overcurrent limiter active |
| otp_flag_i | input | 1 | Die overtemperature |
| uv_flag_i | input | 1 | Supply below the lockout threshold; also the block's reset |
| reset_req_n_i | input | 1 | Active-low reset request |
| sleep_req_n_i | input | 1 | Active-low sleep request |
| bridge_en_o | output | 1 | Permission for the bridge switches to conduct |
| logic_rst_o | output | 1 | One-cycle reinitialisation pulse for the control logic |
| ignore_in_o | output | 1 | Control inputs are to be disregarded |
| clk_stop_o | output | 1 | Stop the charge pump, regulator and clocks |
| fault_n_o | output | 1 | Active-low fault indication |

## Verification
The hardest situations to reach are the ones where one condition is hidden behind another. Examples are a thermal flag that is still high when the wake-up interval expires, or an overcurrent flag that is still high when a reset is released. Only a precise ordering of request edges reaches them. The bench holds sleep, releases it with the thermal flag high, and counts the exact edge on which the block lands in HOT rather than RUN. It holds the overcurrent flag high through a whole reset and then keeps it high for one edge fewer than the qualification window after release, which shows that nothing was counted during the reset. The restart of the wake-up timer is reached by re-asserting sleep partway through the interval and then timing the second release from scratch.

// File: rtl/bsup_pkg.sv
package bsup_pkg;

    typedef enum logic [2:0] {
        ST_POWER_DOWN = 3'd0,
        ST_HELD_RESET = 3'd1,
        ST_SLEEP      = 3'd2,
        ST_WAKE       = 3'd3,
        ST_RUN        = 3'd4,
        ST_HOT        = 3'd5,
        ST_OC_LOCK    = 3'd6
    } sup_state_e;

endpackage

// File: rtl/oc_qualifier.sv
module oc_qualifier #(
    parameter int QUAL_CYCLES = 300
) (
    input  logic clk,
    input  logic arm_i,
    input  logic flag_i,
    output logic trip_o
);
    localparam int CW = $clog2(QUAL_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(QUAL_CYCLES - 1);

    logic [CW-1:0] run_cnt_q;

    always_ff @(posedge clk) begin
        if (!arm_i || !flag_i) begin
            run_cnt_q <= '0;
        end else if (run_cnt_q != LAST) begin
            run_cnt_q <= run_cnt_q + 1'b1;
        end
    end

    assign trip_o = arm_i && flag_i && (run_cnt_q == LAST);

endmodule

// File: rtl/wake_timer.sv
module wake_timer #(
    parameter int WAKE_CYCLES = 100000
) (
    input  logic clk,
    input  logic active_i,
    output logic done_o
);
    localparam int CW = $clog2(WAKE_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(WAKE_CYCLES - 1);

    logic [CW-1:0] elapsed_q;

    always_ff @(posedge clk) begin
        if (!active_i) begin
            elapsed_q <= '0;
        end else if (elapsed_q != LAST) begin
            elapsed_q <= elapsed_q + 1'b1;
        end
    end

    assign done_o = active_i && (elapsed_q == LAST);

endmodule

// File: rtl/supervisor_fsm.sv
module supervisor_fsm
    import bsup_pkg::*;
(
    input  logic       clk,
    input  logic       uv_i,
    input  logic       reset_req_n_i,
    input  logic       sleep_req_n_i,
    input  logic       hot_i,
    input  logic       oc_trip_i,
    input  logic       wake_done_i,
    output sup_state_e state_o,
    output logic       bridge_en_o,
    output logic       logic_rst_o,
    output logic       ignore_in_o,
    output logic       clk_stop_o,
    output logic       fault_n_o
);
    sup_state_e state_q;
    sup_state_e state_d;
    logic       rst_pulse_q;
    logic       cur_in_reset;
    logic       nxt_in_reset;

    always_comb begin
        state_d = state_q;
        if (uv_i) begin
            state_d = ST_POWER_DOWN;
        end else if (!reset_req_n_i) begin
            state_d = ST_HELD_RESET;
        end else if (state_q == ST_OC_LOCK) begin
            state_d = ST_OC_LOCK;
        end else if (!sleep_req_n_i) begin
            state_d = ST_SLEEP;
        end else begin
            unique case (state_q)
                ST_POWER_DOWN, ST_HELD_RESET: state_d = hot_i ? ST_HOT : ST_RUN;
                ST_SLEEP:                     state_d = ST_WAKE;
                ST_WAKE: begin
                    if (wake_done_i) state_d = hot_i ? ST_HOT : ST_RUN;
                    else             state_d = ST_WAKE;
                end
                ST_RUN: begin
                    if (oc_trip_i)  state_d = ST_OC_LOCK;
                    else if (hot_i) state_d = ST_HOT;
                    else            state_d = ST_RUN;
                end
                ST_HOT:     state_d = hot_i ? ST_HOT : ST_RUN;
                ST_OC_LOCK: state_d = ST_OC_LOCK;
                default:    state_d = ST_POWER_DOWN;
            endcase
        end
    end

    assign cur_in_reset = (state_q == ST_POWER_DOWN) || (state_q == ST_HELD_RESET);
    assign nxt_in_reset = (state_d == ST_POWER_DOWN) || (state_d == ST_HELD_RESET);

    always_ff @(posedge clk) begin
        state_q     <= state_d;
        rst_pulse_q <= nxt_in_reset && !cur_in_reset;
    end

    always_comb begin
        bridge_en_o = 1'b0;
        ignore_in_o = 1'b0;
        clk_stop_o  = 1'b0;
        fault_n_o   = 1'b1;
        unique case (state_q)
            ST_POWER_DOWN, ST_HELD_RESET: ignore_in_o = 1'b1;
            ST_SLEEP: begin
                ignore_in_o = 1'b1;
                clk_stop_o  = 1'b1;
            end
            ST_WAKE:    bridge_en_o = 1'b0;
            ST_RUN:     bridge_en_o = 1'b1;
            ST_HOT:     fault_n_o   = 1'b0;
            ST_OC_LOCK: fault_n_o   = 1'b0;
            default:    ignore_in_o = 1'b1;
        endcase
    end

    assign logic_rst_o = rst_pulse_q;
    assign state_o     = state_q;

endmodule

// File: rtl/bridge_supervisor.sv
module bridge_supervisor
    import bsup_pkg::*;
#(
    parameter int OC_QUAL_CYCLES = 300,
    parameter int WAKE_CYCLES    = 100000
) (
    input  logic clk,
    input  logic ocp_flag_i,
    input  logic otp_flag_i,
    input  logic uv_flag_i,
    input  logic reset_req_n_i,
    input  logic sleep_req_n_i,
    output logic bridge_en_o,
    output logic logic_rst_o,
    output logic ignore_in_o,
    output logic clk_stop_o,
    output logic fault_n_o
);
    sup_state_e state_q;
    logic       oc_trip;
    logic       wake_done;
    logic       qual_arm;
    logic       wake_active;

    assign qual_arm    = (state_q == ST_RUN);
    assign wake_active = (state_q == ST_WAKE);

    oc_qualifier #(.QUAL_CYCLES(OC_QUAL_CYCLES)) u_qual (
        .clk    (clk),
        .arm_i  (qual_arm),
        .flag_i (ocp_flag_i),
        .trip_o (oc_trip)
    );

    wake_timer #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
        .clk      (clk),
        .active_i (wake_active),
        .done_o   (wake_done)
    );

    supervisor_fsm u_fsm (
        .clk           (clk),
        .uv_i          (uv_flag_i),
        .reset_req_n_i (reset_req_n_i),
        .sleep_req_n_i (sleep_req_n_i),
        .hot_i         (otp_flag_i),
        .oc_trip_i     (oc_trip),
        .wake_done_i   (wake_done),
        .state_o       (state_q),
        .bridge_en_o   (bridge_en_o),
        .logic_rst_o   (logic_rst_o),
        .ignore_in_o   (ignore_in_o),
        .clk_stop_o    (clk_stop_o),
        .fault_n_o     (fault_n_o)
    );

endmodule

// File: rtl/bridge_supervisor_chk.sv
module bridge_supervisor_chk
    import bsup_pkg::*;
(
    input logic       clk,
    input logic       uv_flag_i,
    input logic       reset_req_n_i,
    input logic       sleep_req_n_i,
    input sup_state_e state_q,
    input logic       bridge_en_o,
    input logic       logic_rst_o,
    input logic       ignore_in_o,
    input logic       clk_stop_o,
    input logic       fault_n_o
);
    assert_reset_holds_R2: assert property (@(posedge clk) disable iff (uv_flag_i)
        !reset_req_n_i |=> (!bridge_en_o && ignore_in_o && !clk_stop_o));

    assert_sleep_stops_R6: assert property (@(posedge clk) disable iff (uv_flag_i)
        (reset_req_n_i && !sleep_req_n_i && state_q != ST_OC_LOCK)
            |=> (clk_stop_o && ignore_in_o && !bridge_en_o));

    assert_lock_persists_R4: assert property (@(posedge clk) disable iff (uv_flag_i)
        (state_q == ST_OC_LOCK && reset_req_n_i) |=> (!fault_n_o && !bridge_en_o));

    assert_no_drive_in_fault_R8: assert property (@(posedge clk) disable iff (uv_flag_i)
        !fault_n_o |-> !bridge_en_o);

    assert_exclusive_outputs_R9: assert property (@(posedge clk) disable iff (uv_flag_i)
        $onehot0({bridge_en_o, clk_stop_o, !fault_n_o}));

    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (uv_flag_i)
        logic_rst_o |=> !logic_rst_o);

endmodule

bind bridge_supervisor bridge_supervisor_chk u_chk (
    .clk           (clk),
    .uv_flag_i     (uv_flag_i),
    .reset_req_n_i (reset_req_n_i),
    .sleep_req_n_i (sleep_req_n_i),
    .state_q       (state_q),
    .bridge_en_o   (bridge_en_o),
    .logic_rst_o   (logic_rst_o),
    .ignore_in_o   (ignore_in_o),
    .clk_stop_o    (clk_stop_o),
    .fault_n_o     (fault_n_o)
);

// File: tb/tb_bridge_supervisor.sv
`timescale 1ns/1ps
module tb_bridge_supervisor;

    localparam int QUAL = 6;
    localparam int WAKE = 8;

    logic clk = 1'b0;
    logic ocp, otp, uv, rst_n, slp_n;
    logic b_en, lrst, ign, cstop, flt_n;
    int   n_tests = 0;
    int   n_fail  = 0;

    always #5 clk = ~clk;

    bridge_supervisor #(.OC_QUAL_CYCLES(QUAL), .WAKE_CYCLES(WAKE)) dut (
        .clk           (clk),
        .ocp_flag_i    (ocp),
        .otp_flag_i    (otp),
        .uv_flag_i     (uv),
        .reset_req_n_i (rst_n),
        .sleep_req_n_i (slp_n),
        .bridge_en_o   (b_en),
        .logic_rst_o   (lrst),
        .ignore_in_o   (ign),
        .clk_stop_o    (cstop),
        .fault_n_o     (flt_n)
    );

    // {ocp, otp, uv, rst_n, slp_n, exp bridge, exp fault_n, exp ignore, exp clk_stop, exp logic_rst}
    localparam logic [9:0] VEC [12] = '{
        10'b00011_11000, // R1 undervoltage gone -> RUN
        10'b01011_00000, // R5 thermal -> HOT
        10'b01011_00000, // R5 stays HOT
        10'b00011_11000, // R5 thermal cleared -> RUN
        10'b00001_01101, // R2 R10 reset -> HELD_RESET with pulse
        10'b00011_11000, // R2 release -> RUN
        10'b00010_01110, // R6 sleep
        10'b00011_01000, // R7 WAKE
        10'b00010_01110, // R7 sleep again restarts
        10'b00111_01101, // R1 R8 R10 undervoltage, no fault
        10'b01111_01100, // R8 thermal hidden by undervoltage
        10'b00011_11000  // R1 resume
    };

    task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [4:0] outs();
        return {b_en, flt_n, ign, cstop, lrst};
    endfunction

    task automatic time_wake(input string req);
        int first = 0;
        slp_n = 1'b1;
        for (int n = 1; n <= 20; n++) begin
            step(1);
            if (b_en && first == 0) first = n;
        end
        chk(req, 5'(first), 5'(WAKE + 1));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete (all requirements)");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        ocp = 1'b0; otp = 1'b0; uv = 1'b1; rst_n = 1'b1; slp_n = 1'b1;
        step(3);
        // R1 reset state under undervoltage
        chk("R1", {b_en, flt_n, ign, cstop}, 4'b0110);

        for (int i = 0; i < 12; i++) begin
            {ocp, otp, uv, rst_n, slp_n} = VEC[i][9:5];
            step(1);
            chk($sformatf("R9 vector %0d", i), outs(), VEC[i][4:0]);
        end

        // R3 short run does not trip
        ocp = 1'b1; step(QUAL - 1);
        chk("R3", {b_en, flt_n}, 2'b11);
        ocp = 1'b0; step(1);
        ocp = 1'b1; step(QUAL - 1);
        ocp = 1'b0; step(1);
        ocp = 1'b1; step(QUAL - 1);
        chk("R3", {b_en, flt_n}, 2'b11);
        ocp = 1'b0; step(1);
        // R3 full run trips
        ocp = 1'b1; step(QUAL);
        chk("R3", {b_en, flt_n}, 2'b00);

        // R4 lock persists
        ocp = 1'b0; step(10);
        chk("R4", {b_en, flt_n}, 2'b00);
        otp = 1'b1; step(2); otp = 1'b0; step(2);
        chk("R4", {b_en, flt_n}, 2'b00);
        slp_n = 1'b0; step(2);
        chk("R4", {b_en, flt_n, cstop}, 3'b000);
        slp_n = 1'b1;

        // R10 R2 reset clears lock, ignores overcurrent
        rst_n = 1'b0; ocp = 1'b1; step(1);
        chk("R10", {b_en, ign, lrst}, 3'b011);
        step(9);
        chk("R10", {lrst, flt_n}, 2'b01);
        rst_n = 1'b1; step(QUAL - 1);
        chk("R2", {b_en, flt_n}, 2'b11);
        ocp = 1'b0; step(1);

        // R4 R8 undervoltage clears lock, no fault by itself
        ocp = 1'b1; step(QUAL);
        chk("R4", flt_n, 1'b0);
        ocp = 1'b0; uv = 1'b1; step(1);
        chk("R8", {b_en, flt_n, lrst}, 3'b011);
        uv = 1'b0; step(1);
        chk("R1", {b_en, flt_n}, 2'b11);

        // R7 wake delay
        slp_n = 1'b0; step(3);
        time_wake("R7");
        // R7 restart
        slp_n = 1'b0; step(2);
        slp_n = 1'b1; step(5);
        chk("R7", b_en, 1'b0);
        slp_n = 1'b0; step(1);
        time_wake("R7");

        // R9 sleep over thermal, R5 thermal at wake end
        otp = 1'b1; slp_n = 1'b0; step(1);
        chk("R9", {cstop, flt_n}, 2'b11);
        slp_n = 1'b1; step(WAKE + 1);
        chk("R5", {b_en, flt_n}, 2'b00);
        otp = 1'b0; step(1);
        chk("R5", {b_en, flt_n}, 2'b11);

        // R9 reset over sleep
        rst_n = 1'b0; slp_n = 1'b0; step(1);
        chk("R9", {ign, cstop}, 2'b10);
        rst_n = 1'b1; slp_n = 1'b1; step(1);
        chk("R9", b_en, 1'b1);

        // R6 sleep flags
        slp_n = 1'b0; step(1);
        chk("R6", {b_en, ign, cstop}, 3'b011);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule